// File: doc/BRIEF.md
# UART Register Front End with FIFO-Level Interrupts

This block is the software-visible side of a simple serial port. It sits on a 32-bit register port and holds a transmit queue and a receive queue of eight bytes each. It also holds the channel enables, the stop-bit choice, the baud divisor, and an interrupt raised by programmable fill-level thresholds. The bit-level serial engines sit beside it. The transmit engine draws bytes from the transmit queue through a valid/ready pair. The receive engine offers each byte it assembles with a one-cycle strobe.

Software pushes a byte by writing the transmit data register. It pops a byte by reading the receive data register. Bit 31 of each data register reports the queue state, so a polling loop needs only one access per byte. The transmit-side interrupt condition is set while the transmit queue is running low. The receive-side condition is set while the receive queue is filling up. Both conditions are levels and clear by themselves when the fill level moves past the threshold.

Top module: `uart_regfile`

## Requirements
- R1: After reset both queues are empty, every control, enable and divisor field is zero, `irq` is low, and reading the receive data register returns 0x8000_0000.
- R2: A write to word index 0 (transmit data) queues bits 7:0. Queued bytes appear on `tx_byte` with `tx_valid` high, oldest first, and each one leaves the queue on a clock edge where `tx_valid` and `tx_ready` are both high.
- R3: Reading word index 0 returns 1 in bit 31 when the transmit queue holds 8 bytes and 0 otherwise, with all other bits zero. A write while the queue holds 8 bytes is dropped.
- R4: A byte strobed with `rx_valid` is queued, unless the receive queue already holds 8 bytes, in which case it is dropped. Reading word index 1 (receive data) returns the oldest byte in bits 7:0 with bit 31 clear and removes it. When the queue is empty the read returns 0x8000_0000 and changes nothing.
- R5: Word index 2 (transmit control) keeps bit 0 (drives `tx_en`), bit 1 (drives `two_stop`, 1 means two stop bits) and bits 18:16 (transmit threshold). All other bits read zero.
- R6: Word index 3 (receive control) keeps bit 0 (drives `rx_en`) and bits 18:16 (receive threshold). All other bits read zero.
- R7: Pending bit 0, read at word index 5, is 1 exactly while the transmit queue holds fewer bytes than the transmit threshold.
- R8: Pending bit 1 is 1 exactly while the receive queue holds more bytes than the receive threshold.
- R9: Word index 4 keeps enable bits 1:0. Word index 5 is read-only and ignores writes. `irq` is the OR over bits 1:0 of enable AND pending.
- R10: Word index 6 keeps a 16-bit divisor in bits 15:0, which drives `divisor`. Bits 31:16 read zero.
- R11: Neither queue ever holds more than 8 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at index 1) |
| reg_addr | input | 3 | Word index of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_ready | input | 1 | Transmit engine takes `tx_byte` |
| rx_valid | input | 1 | Receive engine offers `rx_byte` |
| rx_byte | input | 8 | Received byte |
| tx_en | output | 1 | Transmit channel enable |
| rx_en | output | 1 | Receive channel enable |
| two_stop | output | 1 | Two stop bits when high |
| divisor | output | 16 | Baud divisor |
| irq | output | 1 | Combined interrupt request |

## Verification
The embedded assertions check on every cycle that neither queue exceeds its depth. They also check that a write to a full transmit queue and a read of an empty receive queue leave the fill level untouched, and that a transmit byte waiting for `tx_ready` holds steady. Only the bench scenarios can show the byte order through both queues, the exact threshold crossings in each direction, the reserved-bit masking, and the read-only behaviour of the pending register.

// File: rtl/uart_regfile.sv
module uart_regfile #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16,
  parameter int WM_W  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  input  logic        tx_ready,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic        tx_en,
  output logic        rx_en,
  output logic        two_stop,
  output logic [15:0] divisor,
  output logic        irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [7:0]      tx_mem [DEPTH];
  logic [7:0]      rx_mem [DEPTH];
  logic [PW-1:0]   tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic [WM_W-1:0] tx_wm, rx_wm;
  logic [1:0]      ie_q;
  logic [DIV_W-1:0] div_q;
  logic            tx_full, rx_empty;
  logic            tx_push, tx_pop, rx_push, rx_pop;
  logic [1:0]      pend;

  assign tx_full  = tx_cnt == FULL;
  assign rx_empty = rx_cnt == '0;
  assign tx_push  = reg_wr && reg_addr == 3'd0 && !tx_full;
  assign tx_pop   = tx_valid && tx_ready;
  assign rx_push  = rx_valid && rx_cnt != FULL;
  assign rx_pop   = reg_rd && reg_addr == 3'd1 && !rx_empty;

  assign tx_valid = tx_cnt != '0;
  assign tx_byte  = tx_mem[tx_rp];
  assign divisor  = 16'(div_q);

  assign pend[0] = tx_cnt < CW'(tx_wm);
  assign pend[1] = rx_cnt > CW'(rx_wm);
  assign irq     = |(ie_q & pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= reg_wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en <= 1'b0; two_stop <= 1'b0; tx_wm <= '0;
      rx_en <= 1'b0; rx_wm <= '0;
      ie_q  <= '0;   div_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd2: begin
          tx_en    <= reg_wdata[0];
          two_stop <= reg_wdata[1];
          tx_wm    <= reg_wdata[16 +: WM_W];
        end
        3'd3: begin
          rx_en <= reg_wdata[0];
          rx_wm <= reg_wdata[16 +: WM_W];
        end
        3'd4: ie_q  <= reg_wdata[1:0];
        3'd6: div_q <= reg_wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: reg_rdata[31] = tx_full;
      3'd1: begin
        reg_rdata[31] = rx_empty;
        if (!rx_empty) reg_rdata[7:0] = rx_mem[rx_rp];
      end
      3'd2: begin
        reg_rdata[0] = tx_en;
        reg_rdata[1] = two_stop;
        reg_rdata[16 +: WM_W] = tx_wm;
      end
      3'd3: begin
        reg_rdata[0] = rx_en;
        reg_rdata[16 +: WM_W] = rx_wm;
      end
      3'd4: reg_rdata[1:0] = ie_q;
      3'd5: reg_rdata[1:0] = pend;
      3'd6: reg_rdata[DIV_W-1:0] = div_q;
      default: ;
    endcase
  end

  // R11
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL && rx_cnt <= FULL);

  // R3
  tx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && reg_wr && reg_addr == 3'd0 && !tx_ready) |=> tx_full);

  // R4
  rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && reg_rd && reg_addr == 3'd1 && !rx_valid) |=> rx_empty);

  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));
endmodule

// File: tb/uart_regfile_tb.sv
module uart_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_byte;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_en, rx_en, two_stop, irq;
  logic [15:0] divisor;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  uart_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_en(tx_en), .rx_en(rx_en),
    .two_stop(two_stop), .divisor(divisor), .irq(irq)
  );

  // op: 0 write, 1 read+compare, 2 receive strobe, 3 transmit take+compare, 4 irq compare
  localparam int NV = 38;
  localparam logic [73:0] VEC [NV] = '{
    {3'd1, 3'd3, 4'd6,  32'h0,          32'h0},          // R6 reset value
    {3'd0, 3'd2, 4'd5,  32'hFFFF_FFFF,  32'h0},          // R5 write all ones
    {3'd1, 3'd2, 4'd5,  32'h0,          32'h0007_0003},  // R5 reserved masked
    {3'd1, 3'd5, 4'd7,  32'h0,          32'h1},          // R7 0 < 7
    {3'd4, 3'd0, 4'd9,  32'h0,          32'h0},          // R9 ie zero
    {3'd0, 3'd2, 4'd5,  32'h0002_0001,  32'h0},
    {3'd0, 3'd0, 4'd2,  32'hFFFF_FF41,  32'h0},          // R2 push
    {3'd1, 3'd5, 4'd7,  32'h0,          32'h1},          // R7 1 < 2
    {3'd0, 3'd0, 4'd2,  32'h0000_0042,  32'h0},
    {3'd1, 3'd5, 4'd7,  32'h0,          32'h0},          // R7 2 not < 2
    {3'd1, 3'd0, 4'd3,  32'h0,          32'h0},          // R3 not full
    {3'd3, 3'd0, 4'd2,  32'h0,          32'h41},         // R2 order
    {3'd1, 3'd5, 4'd7,  32'h0,          32'h1},          // R7
    {3'd3, 3'd0, 4'd2,  32'h0,          32'h42},         // R2
    {3'd0, 3'd6, 4'd10, 32'hFFFF_1234,  32'h0},
    {3'd1, 3'd6, 4'd10, 32'h0,          32'h0000_1234},  // R10
    {3'd0, 3'd3, 4'd6,  32'hFFFE_0001,  32'h0},          // wm=6
    {3'd1, 3'd3, 4'd6,  32'h0,          32'h0006_0001},  // R6
    {3'd0, 3'd3, 4'd6,  32'h0001_0001,  32'h0},          // wm=1
    {3'd2, 3'd0, 4'd4,  32'h11,         32'h0},
    {3'd1, 3'd5, 4'd8,  32'h0,          32'h1},          // R8 1 not > 1
    {3'd2, 3'd0, 4'd4,  32'h22,         32'h0},
    {3'd1, 3'd5, 4'd8,  32'h0,          32'h3},          // R8 2 > 1
    {3'd0, 3'd4, 4'd9,  32'hFFFF_FFFF,  32'h0},
    {3'd1, 3'd4, 4'd9,  32'h0,          32'h3},          // R9 ie masked
    {3'd4, 3'd0, 4'd9,  32'h0,          32'h1},          // R9 irq
    {3'd0, 3'd5, 4'd9,  32'h0,          32'h0},          // R9 write to ip
    {3'd1, 3'd5, 4'd9,  32'h0,          32'h3},          // R9 ip unchanged
    {3'd1, 3'd1, 4'd4,  32'h0,          32'h11},         // R4 pop oldest
    {3'd1, 3'd1, 4'd4,  32'h0,          32'h22},         // R4
    {3'd1, 3'd1, 4'd4,  32'h0,          32'h8000_0000},  // R4 empty
    {3'd1, 3'd1, 4'd4,  32'h0,          32'h8000_0000},  // R4 still empty
    {3'd1, 3'd5, 4'd8,  32'h0,          32'h1},          // R8 cleared
    {3'd0, 3'd4, 4'd9,  32'h0000_0002,  32'h0},
    {3'd4, 3'd0, 4'd9,  32'h0,          32'h0},          // R9 only rx enabled
    {3'd0, 3'd2, 4'd7,  32'h0000_0003,  32'h0},          // wm=0, two stop
    {3'd1, 3'd5, 4'd7,  32'h0,          32'h0},          // R7 0 not < 0
    {3'd1, 3'd7, 4'd9,  32'h0,          32'h0}           // unused index
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 0; reg_rd = 0; tx_ready = 0; rx_valid = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); idle(); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 idle();
  endtask

  task automatic rd(input int req, input logic [2:0] a, input logic [31:0] e);
    @(negedge clk); idle(); reg_rd = 1; reg_addr = a; #1;
    chk(req, reg_rdata, e);
    @(posedge clk); #1 idle();
  endtask

  task automatic rxs(input logic [7:0] b);
    @(negedge clk); idle(); rx_valid = 1; rx_byte = b;
    @(posedge clk); #1 idle();
  endtask

  task automatic txt(input int req, input logic [7:0] e);
    @(negedge clk); idle(); tx_ready = 1; #1;
    chk(req, {23'd0, tx_valid, tx_byte}, {23'd0, 1'b1, e});
    @(posedge clk); #1 idle();
  endtask

  initial begin : watchdog
    #500000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(1, {tx_valid, tx_en, rx_en, two_stop, irq}, 5'b0);
    chk(1, {16'd0, divisor}, 32'h0);
    reg_addr = 3'd1; #1 chk(1, reg_rdata, 32'h8000_0000);
    rst_n = 1'b1;
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op, a;
      logic [3:0] rq;
      logic [31:0] d, e;
      {op, a, rq, d, e} = VEC[i];
      case (op)
        3'd0: wr(a, d);
        3'd1: rd(int'(rq), a, e);
        3'd2: rxs(d[7:0]);
        3'd3: txt(int'(rq), e[7:0]);
        default: begin @(negedge clk); #1 chk(int'(rq), {31'd0, irq}, e); end
      endcase
    end

    // R5 control ports
    @(negedge clk); #1 chk(5, {30'd0, tx_en, two_stop}, 32'h3);
    chk(6, {31'd0, rx_en}, 32'h1);
    chk(10, {16'd0, divisor}, 32'h1234);

    // R3 full transmit queue, ninth write dropped
    for (int k = 0; k < 9; k++) wr(3'd0, 32'h60 + k);
    rd(3, 3'd0, 32'h8000_0000);
    for (int k = 0; k < 8; k++) txt(2, 8'(8'h60 + k));
    @(negedge clk); #1 chk(3, {31'd0, tx_valid}, 32'h0);
    rd(3, 3'd0, 32'h0);

    // R4 full receive queue, ninth byte dropped
    for (int k = 0; k < 9; k++) rxs(8'(8'h50 + k));
    for (int k = 0; k < 8; k++) rd(4, 3'd1, 32'h50 + k);
    rd(4, 3'd1, 32'h8000_0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule